// File: doc/BRIEF.md
# Board Control Register Block

A memory-mapped board-control peripheral on a plain 32-bit register bus made of an address, a write strobe, write data and registered read data. It holds the settings that a board management agent changes now and then. These are an 8-bit LED bar, an eight-character text buffer for a small display, a break/reset byte, a general-purpose output byte and a few bit-banged I2C control registers. It also raises a one-cycle system reset request when a specific magic value is written.

Only the low 20 address bits take part in decoding. The text buffer can be filled one character at a time, or all at once from a 32-bit word that expands into eight uppercase hexadecimal digits. The I2C output register drives the clock and data lines directly. The data line is sampled back on a separate input. The bus is a simple control port and has no back-pressure. A write takes effect at the clock edge where the strobe is high, and read data appears one cycle after the address.

Top module: `board_ctrl_regs`

## Requirements
- R1: Decoding uses only address bits [19:0]. Any offset not named in R2 to R9 reads as zero, and a write to it changes no output and no readable register.
- R2: Offsets 0x200 and 0x210 read as zero and ignore writes. Offset 0x208 reads 0x12 when parameter BIG_ENDIAN is 1 and 0x10 when it is 0.
- R3: A write to 0x408 stores bits [7:0] into the LED bar, which drives `led_o` and reads back zero-extended. The LED bar holds its value in every cycle without such a write.
- R4: A write to 0x410 sets all eight characters to the uppercase ASCII hex digits ('0'-'9' = 0x30-0x39, 'A'-'F' = 0x41-0x46) of the write data. Character 0 takes bits [31:28], and each later character takes the next lower nibble.
- R5: A write to offset 0x418 + 8*k, for k = 0..7, sets character k to bits [7:0] of the write data and leaves the other characters unchanged. Character k appears on `disp_chars_o[8k+7:8k]`. The character offsets and 0x410 read as zero.
- R6: A write to 0x500 with data exactly 0x00000042 makes `sys_reset_req_o` high for the one cycle after that write edge. Any other data, and any other cycle, leaves it low.
- R7: Offset 0x508 (break/reset) and offset 0xA00 (general-purpose output) each store bits [7:0] and read them back zero-extended.
- R8: Offset 0xB08 (I2C output enable) stores bits [1:0], and offset 0xB18 (I2C select) stores bit 0. Offset 0xB10 (I2C output) stores the full 32-bit word and drives `i2c_scl_o` from bit 1 and `i2c_sda_o` from bit 0. All three read back.
- R9: Offset 0xA08 returns the I2C output register when I2C select is 1 and returns zero otherwise. Offset 0xB00 returns 0x2 ORed with the level of `i2c_sda_i` in bit 0.
- R10: After reset the values are: LED 0x00, break/reset 0x0A, general-purpose output 0x00, output enable 0x0, I2C output 0x3, select 0x1, all characters 0x20 (space), reset request low and read data zero.
- R11: `bus_rdata` in a cycle is the value at the offset presented one edge earlier. It shows register contents from before any write at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 32 | Register address; bits [19:0] decoded |
| bus_we | input | 1 | Write strobe, one write per high cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| led_o | output | 8 | LED bar |
| disp_chars_o | output | 64 | Eight display characters, character k in bits [8k+7:8k] |
| sys_reset_req_o | output | 1 | One-cycle system reset request |
| i2c_scl_o | output | 1 | I2C clock drive |
| i2c_sda_o | output | 1 | I2C data drive |
| i2c_sda_i | input | 1 | I2C data line sampled back |

## Verification
Every result of this block is due exactly one edge after its stimulus. Read data, the LED bar, the characters, the I2C lines and the reset request all change at the first rising edge after the address or write is presented. The bench drives inputs on falling edges and updates a behavioural model just after each rising edge. The read value is taken from the model state before that edge's write. On the following falling edge every output is compared with the model, so each check lands in the cycle where the result becomes visible. It never lands a cycle early or late.

// File: rtl/bcr_pkg.sv
package bcr_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned OFF_W    = 20;
  localparam int unsigned NCHAR    = 8;
  localparam int unsigned CHAR_W   = 8;
  localparam int unsigned IDX_W    = $clog2(NCHAR);

  localparam logic [OFF_W-1:0] OFF_SWITCH = 20'h00200;
  localparam logic [OFF_W-1:0] OFF_STATUS = 20'h00208;
  localparam logic [OFF_W-1:0] OFF_JUMPER = 20'h00210;
  localparam logic [OFF_W-1:0] OFF_LED    = 20'h00408;
  localparam logic [OFF_W-1:0] OFF_HEXWD  = 20'h00410;
  localparam logic [OFF_W-1:0] OFF_CHAR0  = 20'h00418;
  localparam logic [OFF_W-1:0] OFF_SRST   = 20'h00500;
  localparam logic [OFF_W-1:0] OFF_BRK    = 20'h00508;
  localparam logic [OFF_W-1:0] OFF_GPO    = 20'h00a00;
  localparam logic [OFF_W-1:0] OFF_GPI    = 20'h00a08;
  localparam logic [OFF_W-1:0] OFF_I2CIN  = 20'h00b00;
  localparam logic [OFF_W-1:0] OFF_I2COE  = 20'h00b08;
  localparam logic [OFF_W-1:0] OFF_I2COUT = 20'h00b10;
  localparam logic [OFF_W-1:0] OFF_I2CSEL = 20'h00b18;
  localparam logic [OFF_W-1:0] OFF_CHARN  = OFF_CHAR0 + 20'((NCHAR-1)*8);

  localparam logic [DATA_W-1:0] SRST_MAGIC = 32'h0000_0042;
  localparam logic [CHAR_W-1:0] CHAR_BLANK = 8'h20;

  function automatic logic [CHAR_W-1:0] hex_ascii(input logic [3:0] n);
    return (n < 4'd10) ? (8'h30 + {4'h0, n}) : (8'h37 + {4'h0, n});
  endfunction

  function automatic logic readable(input logic [OFF_W-1:0] off);
    return off inside {OFF_SWITCH, OFF_STATUS, OFF_JUMPER, OFF_LED, OFF_BRK,
                       OFF_GPO, OFF_GPI, OFF_I2CIN, OFF_I2COE, OFF_I2COUT,
                       OFF_I2CSEL};
  endfunction
endpackage

// File: rtl/bcr_display.sv
module bcr_display
  import bcr_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     word_we,
  input  logic [DATA_W-1:0]        word_data,
  input  logic                     char_we,
  input  logic [IDX_W-1:0]         char_idx,
  input  logic [CHAR_W-1:0]        char_data,
  output logic [NCHAR*CHAR_W-1:0]  chars
);
  for (genvar k = 0; k < NCHAR; k++) begin : g_char
    localparam int unsigned MSB = DATA_W - 1 - 4*k;
    always_ff @(posedge clk) begin
      if (!rst_n)
        chars[k*CHAR_W +: CHAR_W] <= CHAR_BLANK;
      else if (word_we)
        chars[k*CHAR_W +: CHAR_W] <= hex_ascii(word_data[MSB -: 4]);
      else if (char_we && char_idx == IDX_W'(k))
        chars[k*CHAR_W +: CHAR_W] <= char_data;
    end
  end

  // R4
  hex_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_we |=> chars[CHAR_W-1:0] == hex_ascii($past(word_data[DATA_W-1 -: 4])));

  // R5
  char_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!word_we && !char_we) |=> $stable(chars));
endmodule

// File: rtl/bcr_i2c.sv
module bcr_i2c
  import bcr_pkg::*;
#(
  parameter logic [1:0] IN_RESET = 2'b11
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              oe_we,
  input  logic              out_we,
  input  logic              sel_we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              sda_i,
  output logic [1:0]        oe_q,
  output logic [DATA_W-1:0] out_q,
  output logic              sel_q,
  output logic [DATA_W-1:0] in_rd,
  output logic              scl_o,
  output logic              sda_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      oe_q  <= '0;
      out_q <= DATA_W'(3);
      sel_q <= 1'b1;
    end else begin
      if (oe_we)  oe_q  <= wdata[1:0];
      if (out_we) out_q <= wdata;
      if (sel_we) sel_q <= wdata[0];
    end
  end

  assign scl_o = out_q[1];
  assign sda_o = out_q[0];
  assign in_rd = {{(DATA_W-2){1'b0}}, IN_RESET[1], sda_i};

  // R8
  line_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_we |=> {scl_o, sda_o} == $past(wdata[1:0]));
endmodule

// File: rtl/board_ctrl_regs.sv
module board_ctrl_regs
  import bcr_pkg::*;
#(
  parameter bit BIG_ENDIAN = 1'b1
)(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [31:0]             bus_addr,
  input  logic                    bus_we,
  input  logic [31:0]             bus_wdata,
  output logic [31:0]             bus_rdata,
  output logic [7:0]              led_o,
  output logic [63:0]             disp_chars_o,
  output logic                    sys_reset_req_o,
  output logic                    i2c_scl_o,
  output logic                    i2c_sda_o,
  input  logic                    i2c_sda_i
);
  localparam logic [DATA_W-1:0] STATUS_VAL = BIG_ENDIAN ? 32'h12 : 32'h10;

  logic [OFF_W-1:0] off;
  logic [11:0]      unused_addr;
  assign off         = bus_addr[OFF_W-1:0];
  assign unused_addr = bus_addr[31:OFF_W];

  // write decode
  logic             char_hit;
  logic [OFF_W-1:0] char_rel;
  assign char_rel = off - OFF_CHAR0;
  assign char_hit = (off >= OFF_CHAR0) && (off <= OFF_CHARN) && (off[2:0] == 3'b000);

  logic [7:0] brk_q, gpo_q;
  logic [1:0] oe_q;
  logic [DATA_W-1:0] i2c_out_q, i2c_in_rd;
  logic sel_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      led_o           <= '0;
      brk_q           <= 8'h0a;
      gpo_q           <= '0;
      sys_reset_req_o <= 1'b0;
    end else begin
      if (bus_we && off == OFF_LED) led_o <= bus_wdata[7:0];
      if (bus_we && off == OFF_BRK) brk_q <= bus_wdata[7:0];
      if (bus_we && off == OFF_GPO) gpo_q <= bus_wdata[7:0];
      sys_reset_req_o <= bus_we && (off == OFF_SRST) && (bus_wdata == SRST_MAGIC);
    end
  end

  bcr_display i_disp (
    .clk       (clk),
    .rst_n     (rst_n),
    .word_we   (bus_we && off == OFF_HEXWD),
    .word_data (bus_wdata),
    .char_we   (bus_we && char_hit),
    .char_idx  (char_rel[3 +: IDX_W]),
    .char_data (bus_wdata[CHAR_W-1:0]),
    .chars     (disp_chars_o)
  );

  bcr_i2c i_i2c (
    .clk    (clk),
    .rst_n  (rst_n),
    .oe_we  (bus_we && off == OFF_I2COE),
    .out_we (bus_we && off == OFF_I2COUT),
    .sel_we (bus_we && off == OFF_I2CSEL),
    .wdata  (bus_wdata),
    .sda_i  (i2c_sda_i),
    .oe_q   (oe_q),
    .out_q  (i2c_out_q),
    .sel_q  (sel_q),
    .in_rd  (i2c_in_rd),
    .scl_o  (i2c_scl_o),
    .sda_o  (i2c_sda_o)
  );

  // read mux, registered
  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    unique case (off)
      OFF_STATUS: rd_mux = STATUS_VAL;
      OFF_LED:    rd_mux = {24'h0, led_o};
      OFF_BRK:    rd_mux = {24'h0, brk_q};
      OFF_GPO:    rd_mux = {24'h0, gpo_q};
      OFF_GPI:    rd_mux = sel_q ? i2c_out_q : '0;
      OFF_I2CIN:  rd_mux = i2c_in_rd;
      OFF_I2COE:  rd_mux = {30'h0, oe_q};
      OFF_I2COUT: rd_mux = i2c_out_q;
      OFF_I2CSEL: rd_mux = {31'h0, sel_q};
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= rd_mux;
  end

  // R1
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !readable(off) |=> bus_rdata == '0);

  // R3
  led_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && off == OFF_LED) |=> $stable(led_o));

  // R6
  srst_magic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_reset_req_o |-> $past(bus_wdata) == SRST_MAGIC && $past(bus_we));

  // R9
  gpi_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (off == OFF_GPI && !sel_q) |=> bus_rdata == '0);
endmodule

// File: tb/test_board_ctrl_regs.sv
`timescale 1ns/1ps
module test_board_ctrl_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  led_o;
  logic [63:0] disp_chars_o;
  logic        sys_reset_req_o, i2c_scl_o, i2c_sda_o;
  logic        i2c_sda_i = 1'b1;

  always #2.5 clk = ~clk;

  board_ctrl_regs #(.BIG_ENDIAN(1'b1)) i_board_ctrl_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .led_o(led_o),
    .disp_chars_o(disp_chars_o), .sys_reset_req_o(sys_reset_req_o),
    .i2c_scl_o(i2c_scl_o), .i2c_sda_o(i2c_sda_o), .i2c_sda_i(i2c_sda_i));

  // behavioural model
  logic [7:0]  m_led, m_brk, m_gpo;
  logic [7:0]  m_chr [8];
  logic [1:0]  m_oe;
  logic [31:0] m_out, m_rdata;
  logic        m_sel, m_rst;
  string       m_tag = "R10";
  bit          cmp_on = 1'b0;
  int          n_chk = 0, n_fail = 0, cycles = 0;

  function automatic logic [7:0] hexc(input logic [3:0] n);
    return (n < 10) ? 8'(48 + n) : 8'(55 + n);
  endfunction

  function automatic logic [31:0] m_read(input logic [19:0] o);
    case (o)
      20'h00208: return 32'h12;
      20'h00408: return {24'h0, m_led};
      20'h00508: return {24'h0, m_brk};
      20'h00a00: return {24'h0, m_gpo};
      20'h00a08: return m_sel ? m_out : 32'h0;
      20'h00b00: return {30'h0, 1'b1, i2c_sda_i};
      20'h00b08: return {30'h0, m_oe};
      20'h00b10: return m_out;
      20'h00b18: return {31'h0, m_sel};
      default:   return 32'h0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one bus cycle; model updated just after the rising edge
  task automatic cyc(input string tag, input logic we, input logic [31:0] a, input logic [31:0] d);
    logic [19:0] o;
    @(negedge clk);
    bus_we = we; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1;
    o = a[19:0];
    m_tag   = tag;
    m_rdata = m_read(o);
    m_rst   = we && o == 20'h00500 && d == 32'h42;
    if (we) begin
      case (o)
        20'h00408: m_led = d[7:0];
        20'h00508: m_brk = d[7:0];
        20'h00a00: m_gpo = d[7:0];
        20'h00b08: m_oe  = d[1:0];
        20'h00b10: m_out = d;
        20'h00b18: m_sel = d[0];
        20'h00410: for (int k = 0; k < 8; k++) m_chr[k] = hexc(d[31-4*k -: 4]);
        default: ;
      endcase
      if (o >= 20'h00418 && o <= 20'h00450 && o[2:0] == 3'b000)
        m_chr[(o - 20'h00418) >> 3] = d[7:0];
    end
    cmp_on = 1'b1;
  endtask

  task automatic wr(input string tag, input logic [31:0] a, input logic [31:0] d);
    cyc(tag, 1'b1, a, d);
    cyc(tag, 1'b0, a, 32'h0);
  endtask

  // compare every output against the model on each falling edge
  always @(negedge clk) begin
    if (cmp_on) begin
      logic [63:0] ed;
      for (int k = 0; k < 8; k++) ed[8*k +: 8] = m_chr[k];
      chk({m_tag, " rdata (R11)"}, {32'h0, bus_rdata}, {32'h0, m_rdata});
      chk("R3 led", {56'h0, led_o}, {56'h0, m_led});
      chk("R4/R5 chars", disp_chars_o, ed);
      chk("R8 scl/sda", {62'h0, i2c_scl_o, i2c_sda_o}, {62'h0, m_out[1:0]});
      chk("R6 reset request", {63'h0, sys_reset_req_o}, {63'h0, m_rst});
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected <= 20000 cycles", cycles);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    m_led = 8'h00; m_brk = 8'h0a; m_gpo = 8'h00; m_oe = 2'b00;
    m_out = 32'h3; m_sel = 1'b1; m_rst = 1'b0; m_rdata = '0;
    for (int k = 0; k < 8; k++) m_chr[k] = 8'h20;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R10 reset values through reads
    cyc("R10", 1'b0, 32'h408, 0); cyc("R10", 1'b0, 32'h508, 0);
    cyc("R10", 1'b0, 32'ha00, 0); cyc("R10", 1'b0, 32'hb08, 0);
    cyc("R10", 1'b0, 32'hb10, 0); cyc("R10", 1'b0, 32'hb18, 0);
    // R2 status and fixed-zero registers
    cyc("R2", 1'b0, 32'h208, 0);
    wr("R2", 32'h200, 32'hffff_ffff); wr("R2", 32'h210, 32'h1234_5678);
    // R3 LED bar keeps 8 bits; R11 read shows old value at a write edge
    cyc("R11", 1'b1, 32'h408, 32'h0000_01a5);
    cyc("R3", 1'b0, 32'h408, 0);
    // R1 upper address bits ignored, unmapped offsets inert
    wr("R1", 32'hfff0_0408, 32'h3c);
    wr("R1", 32'h0000_0404, 32'hdead_beef);
    wr("R1", 32'h0000_0b20, 32'h5);
    // R4 hex word expansion
    wr("R4", 32'h410, 32'h0123_abcf);
    wr("R4", 32'h410, 32'hfedc_9845);
    // R5 single characters
    wr("R5", 32'h418, 32'h141);
    wr("R5", 32'h450, 32'h5a);
    wr("R5", 32'h430, 32'h21);
    wr("R5", 32'h41c, 32'h77);
    // R6 magic value only
    wr("R6", 32'h500, 32'h42);
    wr("R6", 32'h500, 32'h43);
    wr("R6", 32'h500, 32'h142);
    wr("R6", 32'h504, 32'h42);
    // R7 break and general-purpose output
    wr("R7", 32'h508, 32'h1ff); wr("R7", 32'ha00, 32'h5a5);
    // R8 I2C registers and lines
    wr("R8", 32'hb08, 32'hff);
    wr("R8", 32'hb10, 32'h2);
    wr("R8", 32'hb10, 32'h8001);
    // R9 general-purpose input and live data line
    cyc("R9", 1'b0, 32'ha08, 0);
    wr("R9", 32'hb18, 32'h0);
    cyc("R9", 1'b0, 32'ha08, 0);
    wr("R9", 32'hb18, 32'h3);
    cyc("R9", 1'b0, 32'ha08, 0);
    i2c_sda_i = 1'b0; cyc("R9", 1'b0, 32'hb00, 0);
    i2c_sda_i = 1'b1; cyc("R9", 1'b0, 32'hb00, 0);
    // R11 back-to-back reads
    cyc("R11", 1'b0, 32'h508, 0); cyc("R11", 1'b0, 32'ha00, 0); cyc("R11", 1'b0, 32'h408, 0);
    @(negedge clk); @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule